// File: doc/BRIEF.md
# Card Interface Interrupt Status Register

This block is the interrupt status register of a memory-card host controller. It keeps two sticky event flags and one live status bit in one 8-bit register. The card-change flag records any level change on the card-identification pin. The FIFO-ready flag records a DMA start that was requested while the FIFO was not yet at its programmed threshold. The threshold bit shows whether the FIFO fill level currently meets that threshold. Both sticky flags are ORed into one registered interrupt request.

Software clears a sticky flag with a two-step sequence. It first reads the register and sees the flag at 1, then writes 0 to that bit. The per-flag enable bits, the DMA-enable write strobe, the FIFO fill level and the threshold all come from neighbouring logic as plain inputs. Software keeps the FIFO-ready flag quiet by dropping its enable, because the flag sets again every time its condition recurs.

Top module: `cardif_irq_status`

## Requirements
- R1: Read data bits 7..3 are always 0, and writing 1s to them changes nothing.
- R2: After reset the register reads 8'h02: card-change flag (bit 2) 0, threshold bit (bit 1) 1, FIFO-ready flag (bit 0) 0, and the interrupt request is 0.
- R3: A change of the card-identification pin in either direction passes through a two-flop synchronizer and an edge detector. It sets bit 2 on the third rising clock edge after the pin change, provided the card-change enable is 1 in the cycle before that edge.
- R4: A pin change while the card-change enable is 0 leaves bit 2 at 0.
- R5: A DMA-enable strobe with the FIFO-ready enable at 1 and the fill level below the threshold sets bit 0 on that clock edge.
- R6: A DMA-enable strobe sets nothing when the fill level is greater than or equal to the threshold, or when the FIFO-ready enable is 0.
- R7: Bit 1 reads 0 when the fill level sampled at the previous edge was greater than or equal to the threshold, and 1 otherwise. It is read-only.
- R8: Bits 2 and 0 each clear only on a write of 0 that follows a read which returned that bit as 1. The tag from a read is used up by the next write. Writing 1, or writing 0 without such a read, leaves the bit unchanged. The two bits clear independently.
- R9: If a set event and a valid clear fall on the same edge, the bit stays 1.
- R10: The interrupt request equals the OR of bits 2 and 0 as they were one clock earlier.
- R11: After bit 0 is cleared, a later qualifying DMA-enable strobe sets it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| card_id_pin | input | 1 | Asynchronous card-identification pin |
| cdi_ie | input | 1 | Card-change flag enable |
| frdy_ie | input | 1 | FIFO-ready flag enable |
| dma_en_wr | input | 1 | One-cycle strobe: DMA enable written to 1 |
| fifo_level | input | LVL_W | Current FIFO fill level |
| fifo_thr | input | LVL_W | DMA assert threshold |
| reg_sel | input | 1 | Register select |
| reg_rd | input | 1 | Read strobe (with select) |
| reg_wr | input | 1 | Write strobe (with select) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| irq_req | output | 1 | Interrupt request |

## Verification
The bench targets the clear handshake at its edges:
- A write of 0 with no read first must be ignored. A design that cleared on any 0 write would drop the flag at that point.
- A read of 1 followed by a write of 1 uses up the tag. A design that kept the tag would then clear on a later write of 0 that had no new read.
- A set and a valid clear on the same edge must leave the flag at 1. A design with the wrong priority would lose the event.

It also drives falling as well as rising pin changes, since a rising-only detector misses card removal. It strobes DMA enable exactly at level equal to threshold, where an off-by-one comparison would set the flag. A randomized phase compares every cycle against the reference model, which exposes any extra or missing register stage.

// File: rtl/cardif_pkg.sv
package cardif_pkg;

    localparam int REG_W    = 8;
    localparam int BIT_CDI  = 2;
    localparam int BIT_TU   = 1;
    localparam int BIT_FRDY = 0;
    localparam int NUM_CLR  = 2;

    typedef enum int {
        FLG_FRDY = 0,
        FLG_CDI  = 1
    } flag_idx_e;

    typedef struct packed {
        logic cdi;
        logic tu;
        logic frdy;
    } stat_t;

    function automatic int flag_pos(int idx);
        return (idx == FLG_CDI) ? BIT_CDI : BIT_FRDY;
    endfunction

    function automatic logic [REG_W-1:0] pack_stat(stat_t s);
        logic [REG_W-1:0] v;
        v = '0;
        v[BIT_CDI]  = s.cdi;
        v[BIT_TU]   = s.tu;
        v[BIT_FRDY] = s.frdy;
        return v;
    endfunction

endpackage

// File: rtl/cardif_sync_edge.sv
module cardif_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic edge_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain_q[STAGES-1];
    end

    assign edge_o = chain_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/cardif_fifo_cmp.sv
module cardif_fifo_cmp #(
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] level_i,
    input  logic [LVL_W-1:0] thr_i,
    output logic             met_o,
    output logic             tu_o
);
    assign met_o = (level_i >= thr_i);

    always_ff @(posedge clk) begin
        if (rst) tu_o <= 1'b1;
        else     tu_o <= ~met_o;
    end

    p_tu_follows_r7: assert property (@(posedge clk) disable iff (rst)
        met_o |=> !tu_o);
    p_tu_unmet_r7: assert property (@(posedge clk) disable iff (rst)
        !met_o |=> tu_o);

endmodule

// File: rtl/cardif_clr_flag.sv
module cardif_clr_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic flag_o
);
    logic tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
            tag_q  <= 1'b0;
        end else begin
            if (set_i)
                flag_o <= 1'b1;
            else if (wr_i && tag_q && !wbit_i)
                flag_o <= 1'b0;
            if (wr_i)
                tag_q <= 1'b0;
            else if (rd_i)
                tag_q <= flag_o;
        end
    end

    p_hold_untagged_r8: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !tag_q) |=> flag_o);
    p_write_one_keeps_r8: assert property (@(posedge clk) disable iff (rst)
        (flag_o && wr_i && wbit_i) |=> flag_o);
    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);

endmodule

// File: rtl/cardif_irq_status.sv
module cardif_irq_status
    import cardif_pkg::*;
#(
    parameter int LVL_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             card_id_pin,
    input  logic             cdi_ie,
    input  logic             frdy_ie,
    input  logic             dma_en_wr,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [LVL_W-1:0] fifo_thr,
    input  logic             reg_sel,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq_req
);
    logic               pin_edge;
    logic               thr_met;
    logic               thr_tu;
    logic               rd_hit;
    logic               wr_hit;
    logic [NUM_CLR-1:0] set_vec;
    logic [NUM_CLR-1:0] flag_vec;
    stat_t              stat;

    assign rd_hit = reg_sel & reg_rd;
    assign wr_hit = reg_sel & reg_wr;

    cardif_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (card_id_pin),
        .edge_o (pin_edge)
    );

    cardif_fifo_cmp #(.LVL_W(LVL_W)) i_cmp (
        .clk     (clk),
        .rst     (rst),
        .level_i (fifo_level),
        .thr_i   (fifo_thr),
        .met_o   (thr_met),
        .tu_o    (thr_tu)
    );

    assign set_vec[FLG_CDI]  = pin_edge & cdi_ie;
    assign set_vec[FLG_FRDY] = dma_en_wr & frdy_ie & ~thr_met;

    generate
        for (genvar f = 0; f < NUM_CLR; f++) begin : g_flag
            localparam int POS = flag_pos(f);
            cardif_clr_flag i_flag (
                .clk    (clk),
                .rst    (rst),
                .set_i  (set_vec[f]),
                .rd_i   (rd_hit),
                .wr_i   (wr_hit),
                .wbit_i (reg_wdata[POS]),
                .flag_o (flag_vec[f])
            );
        end
    endgenerate

    always_comb begin
        stat.cdi  = flag_vec[FLG_CDI];
        stat.tu   = thr_tu;
        stat.frdy = flag_vec[FLG_FRDY];
    end

    assign reg_rdata = pack_stat(stat);

    always_ff @(posedge clk) begin
        if (rst) irq_req <= 1'b0;
        else     irq_req <= stat.cdi | stat.frdy;
    end

    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[REG_W-1:3] == '0);
    p_cdi_set_r3: assert property (@(posedge clk) disable iff (rst)
        (pin_edge && cdi_ie) |=> stat.cdi);
    p_cdi_masked_r4: assert property (@(posedge clk) disable iff (rst)
        (!stat.cdi && !cdi_ie) |=> !stat.cdi);
    p_frdy_set_r5: assert property (@(posedge clk) disable iff (rst)
        (dma_en_wr && frdy_ie && !thr_met) |=> stat.frdy);
    p_frdy_blocked_r6: assert property (@(posedge clk) disable iff (rst)
        (!stat.frdy && (!dma_en_wr || !frdy_ie || thr_met)) |=> !stat.frdy);
    p_irq_high_r10: assert property (@(posedge clk) disable iff (rst)
        (stat.cdi || stat.frdy) |=> irq_req);
    p_irq_low_r10: assert property (@(posedge clk) disable iff (rst)
        (!stat.cdi && !stat.frdy) |=> !irq_req);

endmodule

// File: tb/test_cardif_irq_status.sv
module test_cardif_irq_status;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       card_id_pin = 1'b0;
    logic       cdi_ie = 1'b0;
    logic       frdy_ie = 1'b0;
    logic       dma_en_wr = 1'b0;
    logic [7:0] fifo_level = 8'd0;
    logic [7:0] fifo_thr = 8'd4;
    logic       reg_sel = 1'b0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cardif_irq_status i_cardif_irq_status (
        .clk(clk), .rst(rst), .card_id_pin(card_id_pin), .cdi_ie(cdi_ie),
        .frdy_ie(frdy_ie), .dma_en_wr(dma_en_wr), .fifo_level(fifo_level),
        .fifo_thr(fifo_thr), .reg_sel(reg_sel), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req)
    );

    // behavioural reference model
    int m_p1, m_p2, m_p3, m_cdi, m_frdy, m_tu, m_irq, m_tcdi, m_tfrdy;
    int n_cdi, n_frdy, n_tcdi, n_tfrdy;
    bit rdp, wrp, met, edge_seen;

    always @(posedge clk) begin
        if (rst) begin
            m_p1 = 0; m_p2 = 0; m_p3 = 0; m_cdi = 0; m_frdy = 0;
            m_tu = 1; m_irq = 0; m_tcdi = 0; m_tfrdy = 0;
        end else begin
            rdp = reg_sel && reg_rd;
            wrp = reg_sel && reg_wr;
            met = (fifo_level >= fifo_thr);
            edge_seen = (m_p2 != m_p3);
            n_cdi = m_cdi;
            n_frdy = m_frdy;
            if (wrp && m_tcdi != 0 && !reg_wdata[2]) n_cdi = 0;
            if (wrp && m_tfrdy != 0 && !reg_wdata[0]) n_frdy = 0;
            if (edge_seen && cdi_ie) n_cdi = 1;
            if (dma_en_wr && frdy_ie && !met) n_frdy = 1;
            n_tcdi = wrp ? 0 : (rdp ? m_cdi : m_tcdi);
            n_tfrdy = wrp ? 0 : (rdp ? m_frdy : m_tfrdy);
            m_irq = (m_cdi != 0 || m_frdy != 0) ? 1 : 0;
            m_cdi = n_cdi; m_frdy = n_frdy;
            m_tcdi = n_tcdi; m_tfrdy = n_tfrdy;
            m_tu = met ? 0 : 1;
            m_p3 = m_p2; m_p2 = m_p1; m_p1 = int'(card_id_pin);
        end
    end

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R8 rdata vs model", int'(reg_rdata),
                  (m_cdi << 2) | (m_tu << 1) | m_frdy);
            check("R10 irq vs model", int'(irq_req), m_irq);
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic rd_reg();
        reg_sel = 1; reg_rd = 1; tick(); reg_sel = 0; reg_rd = 0;
    endtask

    task automatic wr_reg(logic [7:0] d);
        reg_sel = 1; reg_wr = 1; reg_wdata = d; tick();
        reg_sel = 0; reg_wr = 0; reg_wdata = 8'd0;
    endtask

    task automatic dma_pulse();
        dma_en_wr = 1; tick(); dma_en_wr = 0;
    endtask

    task automatic look(string tag, int act, int exp);
        @(negedge clk);
        check(tag, act, exp);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick(3);
        @(negedge clk);
        check("R2 reset rdata", int'(reg_rdata), 8'h02);
        check("R2 reset irq", int'(irq_req), 0);
        rst = 0;
        tick(2);

        fifo_level = 8'd5; tick();
        @(negedge clk); check("R7 met gives bit1 0", int'(reg_rdata[1]), 0);
        fifo_level = 8'd3; tick();
        @(negedge clk); check("R7 unmet gives bit1 1", int'(reg_rdata[1]), 1);

        wr_reg(8'hFF);
        @(negedge clk); check("R1 reserved after write", int'(reg_rdata), 8'h02);

        cdi_ie = 0; card_id_pin = 1; tick(5);
        @(negedge clk); check("R4 masked pin change", int'(reg_rdata[2]), 0);

        cdi_ie = 1; card_id_pin = 0; tick(3);
        @(negedge clk); check("R3 falling edge sets", int'(reg_rdata[2]), 1);
        tick();
        @(negedge clk); check("R10 irq follows flag", int'(irq_req), 1);

        wr_reg(8'h00);
        @(negedge clk); check("R8 write0 without read", int'(reg_rdata[2]), 1);
        rd_reg(); wr_reg(8'h04);
        @(negedge clk); check("R8 write1 keeps", int'(reg_rdata[2]), 1);
        wr_reg(8'h00);
        @(negedge clk); check("R8 tag used up", int'(reg_rdata[2]), 1);
        rd_reg(); wr_reg(8'h00);
        @(negedge clk); check("R8 read1 then write0 clears", int'(reg_rdata[2]), 0);
        tick();
        @(negedge clk); check("R10 irq drops", int'(irq_req), 0);

        card_id_pin = 1; tick(3);
        @(negedge clk); check("R3 rising edge sets", int'(reg_rdata[2]), 1);
        cdi_ie = 0;

        frdy_ie = 1; fifo_level = 8'd1; fifo_thr = 8'd4; dma_pulse();
        @(negedge clk); check("R5 strobe below threshold", int'(reg_rdata[0]), 1);

        rd_reg(); wr_reg(8'hFE);
        @(negedge clk); check("R8 per-bit clear frdy", int'(reg_rdata[0]), 0);
        check("R8 per-bit cdi kept", int'(reg_rdata[2]), 1);

        fifo_level = 8'd4; dma_pulse();
        @(negedge clk); check("R6 level equal threshold", int'(reg_rdata[0]), 0);
        fifo_level = 8'd2; frdy_ie = 0; dma_pulse();
        @(negedge clk); check("R6 enable low", int'(reg_rdata[0]), 0);

        frdy_ie = 1; dma_pulse();
        @(negedge clk); check("R11 sets again after clear", int'(reg_rdata[0]), 1);

        rd_reg();
        reg_sel = 1; reg_wr = 1; reg_wdata = 8'h00; dma_en_wr = 1; tick();
        reg_sel = 0; reg_wr = 0; dma_en_wr = 0;
        @(negedge clk); check("R9 set wins over clear", int'(reg_rdata[0]), 1);
        check("R8 cdi cleared same write", int'(reg_rdata[2]), 0);

        for (int i = 0; i < 3000; i++) begin
            card_id_pin = ($urandom_range(0, 7) == 0) ? ~card_id_pin : card_id_pin;
            cdi_ie = ($urandom_range(0, 3) != 0);
            frdy_ie = ($urandom_range(0, 3) != 0);
            dma_en_wr = ($urandom_range(0, 5) == 0);
            fifo_level = 8'($urandom_range(0, 8));
            fifo_thr = 8'($urandom_range(0, 8));
            reg_sel = ($urandom_range(0, 3) != 0);
            case ($urandom_range(0, 3))
                0: begin reg_rd = 1; reg_wr = 0; end
                1: begin reg_rd = 0; reg_wr = 1; end
                default: begin reg_rd = 0; reg_wr = 0; end
            endcase
            reg_wdata = 8'($urandom_range(0, 255));
            tick();
        end
        reg_sel = 0; reg_rd = 0; reg_wr = 0; dma_en_wr = 0;
        tick(2);
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule